// File: doc/BRIEF.md
# Shift-Add Synaptic Current Decay Unit

This block applies one step of exponential decay to a signed 32-bit synaptic current held in Q15.16 fixed point. Each clock it produces `I - I/tau`, where the division by the time constant `tau` has no divider behind it. It is replaced by a sum of arithmetic right shifts of `I`. Only four time constants are offered: 2, 3, 7 and 8. Division by 2 and by 8 is exact up to the truncation of the shift. Division by 3 and by 7 is an approximation whose error is known and small.

The time constant is picked by a 2-bit code held in a configuration register, which is written through a write strobe. A neuron-update loop writes the code once and then streams one current per clock into `currIn`. Each decayed value appears on `decayOut` one clock later. Because all shifts are arithmetic, negative currents of ordinary magnitude decay toward zero just as positive ones do.

Top module: `decay_top`

## Requirements
- R1: While `rst` is high, at every rising edge `decayOut` is cleared to 0 and the time-constant code is set to 2'b00 (divide by 2).
- R2: A rising edge with `cfgWe` high loads `cfgTau` into the time-constant register. That code governs the result computed at the next edge and at every edge after it. While `cfgWe` is low the code does not change.
- R3: With code 2'b00, the result is `I - (I>>>1)`.
- R4: With code 2'b01, the result is `I - ((I>>>2)+(I>>>4)+(I>>>6)+(I>>>8))`.
- R5: With code 2'b10, the result is `I - ((I>>>3)+(I>>>6)+(I>>>9))`.
- R6: With code 2'b11, the result is `I - (I>>>3)`.
- R7: `decayOut` is a register. After the edge at which `currIn` and the stored code are sampled, it shows the result for those values. The latency is exactly one clock, and a new result follows on every clock.
- R8: For |I| of at least 2^20, the subtracted amount `I - decayOut` lies within 0.4% of the true quotient `I/tau`, for every code.
- R9: A non-negative input gives a result between 0 and that input, inclusive. A zero input gives zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cfgWe | input | 1 | Write strobe for the time-constant register |
| cfgTau | input | 2 | Time-constant code: 00=2, 01=3, 10=7, 11=8 |
| currIn | input | 32 | Signed Q15.16 synaptic current to decay |
| decayOut | output | 32 | Signed Q15.16 decayed current, registered |

## Verification
Each decayed value is due on `decayOut` exactly one rising edge after its `currIn` was applied. The bench therefore drives inputs at the falling edge and compares one time step after the next rising edge. A configuration write changes the code used at the following edge, not at the edge that stores it. The reference model keeps the old code for the result sampled together with the write and switches only afterwards. The accuracy bound is checked on those same samples against a real-valued quotient computed in the bench.

// File: rtl/decay_pkg.sv
package decay_pkg;

  localparam int SEL_W     = 2;
  localparam int NUM_SEL   = 1 << SEL_W;
  localparam int MAX_SHIFT = 9;

  typedef enum logic [SEL_W-1:0] {
    TAU_DIV2 = 2'b00,
    TAU_DIV3 = 2'b01,
    TAU_DIV7 = 2'b10,
    TAU_DIV8 = 2'b11
  } tauCode_e;

  // strobes from control to datapath: one-hot divisor select
  typedef struct packed {
    logic [NUM_SEL-1:0] selOneHot;
  } decayStrobe_t;

  // bit s set => term (x >>> s) is part of the quotient estimate
  function automatic logic [MAX_SHIFT:0] termMask(input int idx);
    logic [MAX_SHIFT:0] m;
    m = '0;
    case (idx)
      0:       m[1] = 1'b1;
      1:       begin m[2] = 1'b1; m[4] = 1'b1; m[6] = 1'b1; m[8] = 1'b1; end
      2:       begin m[3] = 1'b1; m[6] = 1'b1; m[9] = 1'b1; end
      default: m[3] = 1'b1;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/decay_ctrl.sv
module decay_ctrl
  import decay_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                cfgWe,
  input  logic [SEL_W-1:0]    cfgTau,
  output tauCode_e            tauCode,
  output decayStrobe_t        strobe
);

  tauCode_e tauReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      tauReg <= TAU_DIV2;
    end else if (cfgWe) begin
      tauReg <= tauCode_e'(cfgTau);
    end
  end

  always_comb begin
    strobe.selOneHot = '0;
    strobe.selOneHot[tauReg] = 1'b1;
  end

  assign tauCode = tauReg;

endmodule

// File: rtl/decay_dp.sv
module decay_dp
  import decay_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic signed [DATA_W-1:0]  currIn,
  input  decayStrobe_t              strobe,
  output logic signed [DATA_W-1:0]  decayOut
);

  logic signed [DATA_W-1:0] partSum [NUM_SEL][MAX_SHIFT+1];
  logic signed [DATA_W-1:0] quotient [NUM_SEL];
  logic signed [DATA_W-1:0] chosen;

  for (genvar o = 0; o < NUM_SEL; o++) begin : g_opt
    localparam logic [MAX_SHIFT:0] MASK = termMask(o);
    assign partSum[o][0] = '0;
    for (genvar s = 1; s <= MAX_SHIFT; s++) begin : g_term
      if (MASK[s]) begin : g_use
        logic signed [DATA_W-1:0] shifted;
        assign shifted = currIn >>> s;
        assign partSum[o][s] = partSum[o][s-1] + shifted;
      end else begin : g_skip
        assign partSum[o][s] = partSum[o][s-1];
      end
    end
    assign quotient[o] = partSum[o][MAX_SHIFT];
  end

  always_comb begin
    chosen = '0;
    for (int o = 0; o < NUM_SEL; o++) begin
      if (strobe.selOneHot[o]) chosen = chosen | quotient[o];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      decayOut <= '0;
    end else begin
      decayOut <= currIn - chosen;
    end
  end

endmodule

// File: rtl/decay_top.sv
module decay_top
  import decay_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfgWe,
  input  logic [1:0]                cfgTau,
  input  logic signed [DATA_W-1:0]  currIn,
  output logic signed [DATA_W-1:0]  decayOut
);

  tauCode_e     tauCode;
  decayStrobe_t strobe;

  decay_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .cfgWe   (cfgWe),
    .cfgTau  (cfgTau),
    .tauCode (tauCode),
    .strobe  (strobe)
  );

  decay_dp #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .currIn   (currIn),
    .strobe   (strobe),
    .decayOut (decayOut)
  );

endmodule

// File: rtl/decay_chk.sv
module decay_chk
  import decay_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfgWe,
  input  logic [1:0]                cfgTau,
  input  logic signed [DATA_W-1:0]  currIn,
  input  logic signed [DATA_W-1:0]  decayOut,
  input  tauCode_e                  tauCode,
  input  decayStrobe_t              strobe
);

  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (rst)
    cfgWe |=> (tauCode == tauCode_e'($past(cfgTau)))) else $error("cfg load"); // R2
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cfgWe |=> $stable(tauCode)) else $error("cfg hold"); // R2
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones(strobe.selOneHot) == 1) else $error("select not one-hot"); // R2
  AST_ZERO_IN: assert property (@(posedge clk) disable iff (rst)
    (currIn == '0) |=> (decayOut == '0)) else $error("zero input"); // R9
  AST_POS_RANGE: assert property (@(posedge clk) disable iff (rst)
    !currIn[DATA_W-1] |=> (!decayOut[DATA_W-1] && decayOut <= $past(currIn))) else $error("range"); // R9
  AST_DIV2_EXACT: assert property (@(posedge clk) disable iff (rst)
    (tauCode == TAU_DIV2) |=> (decayOut == $past(currIn) - ($past(currIn) >>> 1))) else $error("div2"); // R3

endmodule

bind decay_top decay_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cfgWe    (cfgWe),
  .cfgTau   (cfgTau),
  .currIn   (currIn),
  .decayOut (decayOut),
  .tauCode  (tauCode),
  .strobe   (strobe)
);

// File: tb/tb_decay_top.sv
`timescale 1ns/1ps
module tb_decay_top;

  localparam int CLK_PERIOD = 10;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               cfgWe = 1'b0;
  logic [1:0]         cfgTau = 2'b00;
  logic signed [31:0] currIn = '0;
  logic signed [31:0] decayOut;

  int checks = 0;
  int errors = 0;
  int tauModel = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  decay_top dut (
    .clk(clk), .rst(rst), .cfgWe(cfgWe), .cfgTau(cfgTau),
    .currIn(currIn), .decayOut(decayOut)
  );

  function automatic longint approxQuot(longint x, int code);
    case (code)
      0:       return x >>> 1;
      1:       return (x >>> 2) + (x >>> 4) + (x >>> 6) + (x >>> 8);
      2:       return (x >>> 3) + (x >>> 6) + (x >>> 9);
      default: return x >>> 3;
    endcase
  endfunction

  function automatic real tauValue(int code);
    case (code)
      0: return 2.0;
      1: return 3.0;
      2: return 7.0;
      default: return 8.0;
    endcase
  endfunction

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one clock: apply at negedge, sample after the next posedge
  task automatic step(input int cur, input bit we, input int tau, input string req);
    longint x, exp, sub;
    real q, err;
    @(negedge clk);
    currIn = cur; cfgWe = we; cfgTau = tau[1:0];
    @(posedge clk); #1;
    x = cur;
    exp = x - approxQuot(x, tauModel);
    check(req, decayOut, exp);
    if (x >= 1048576 || x <= -1048576) begin          // R8
      sub = x - longint'(decayOut);
      q = real'(x) / tauValue(tauModel);
      err = (real'(sub) - q) / q;
      if (err < 0.0) err = -err;
      checks++;
      if (err > 0.004) begin
        errors++;
        $display("FAIL R8: actual %0d expected %f (rel err %f)", sub, q, err);
      end
    end
    if (we) tauModel = tau;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset clears output and selects divide-by-2
    @(negedge clk); currIn = 32'sd123456;
    repeat (2) @(posedge clk); #1;
    check("R1 reset output", decayOut, 0);
    @(negedge clk); rst = 1'b0;
    step(32'sd65536, 0, 0, "R1 default code /2");
    step(32'sd65536 * 100, 0, 0, "R3 /2");
    step(-32'sd65536 * 100, 0, 0, "R3 /2 negative");
    step(32'sd7, 0, 0, "R3 /2 odd small");
    // R2: write takes effect on the following edge
    step(32'sd9437184, 1, 1, "R2 old code during write");
    step(32'sd9437184, 0, 0, "R4 /3 after write");
    step(-32'sd9437184, 0, 0, "R4 /3 negative");
    step(32'sd3, 0, 0, "R4 /3 small");
    step(32'sd16777216, 1, 2, "R2 write /7");
    step(32'sd16777216, 0, 0, "R5 /7");
    step(-32'sd20000000, 0, 0, "R5 /7 negative");
    step(32'sd16777216, 1, 3, "R2 write /8");
    step(32'sd16777216, 0, 0, "R6 /8");
    step(32'sh7FFFFFFF, 0, 0, "R6 /8 max positive");
    step(32'sh80000000, 0, 0, "R6 /8 most negative");
    step(0, 0, 0, "R9 zero input");
    // R7: back-to-back values, one result per clock
    for (int i = 0; i < 20; i++) step(i * 1000003, 0, 0, "R7 streaming");
    // R2: hold when strobe low, with cfgTau wiggling
    step(32'sd4000000, 0, 0, "R2 hold (cfgTau ignored)");
    step(32'sd4000000, 0, 1, "R2 hold /8 kept");
    // sweep all codes with random values, R3-R9
    for (int c = 0; c < 4; c++) begin
      step(32'sd1, 1, c, "R2 sweep write");
      for (int k = 0; k < 200; k++) begin
        int v;
        v = int'($urandom);
        step(v, 0, 0, "R3-6 random");
        if (v >= 0) begin
          checks++;
          if (decayOut < 0 || decayOut > v) begin
            errors++;
            $display("FAIL R9: actual %0d expected 0..%0d", decayOut, v);
          end
        end
      end
    end
    // R1: reset mid-run restores code 00
    @(negedge clk); rst = 1'b1; cfgWe = 1'b0;
    @(posedge clk); #1;
    check("R1 reset clears", decayOut, 0);
    tauModel = 0;
    @(negedge clk); rst = 1'b0;
    step(32'sd800000, 0, 0, "R1 code back to /2");
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule